// File: doc/BRIEF.md
# Circular Dual-Operand Word Fetcher

This block fetches operand pairs for a multiply-accumulate datapath from a shared single-port SRAM. It keeps two independent circular windows in that memory, one for the X operand stream and one for the Y operand stream. Each window has a base word address, a length in words and a step in words. The block reads one X word and then one Y word, and presents the two together as one operand pair on a valid/ready handshake.

The block competes with other masters for the SRAM. It raises an ownership request, and while the request is granted it issues single-word reads. Each accepted read counts as one burst cycle. After a programmed number of accepted reads it gives the memory up. It asks again only in a cycle after one in which no other requester was waiting. If the operand consumer stops taking pairs, the block stops issuing reads but keeps ownership. Dropping `run` returns both windows to their base addresses and discards the operand pair it holds.

The configuration inputs must be held steady while `run` is high. A legal configuration has a window length of at least 1 and a step smaller than the length.

Top module: `circ_operand_fetch`

## Requirements
- R1: While reset is asserted and directly after it, `mem_req`, `mem_rd` and `op_valid` are 0.
- R2: The X read addresses are `x_base + off` modulo 2^AW. `off` starts at 0. After each X read, `off` becomes `off + x_step`, less `x_len` when that sum is at least `x_len`.
- R3: The Y read addresses follow the same rule with `y_base`, `y_len` and `y_step`, and are independent of the X sequence.
- R4: An accepted read is a cycle with `mem_rd` and `mem_gnt` both high. Accepted reads alternate X, Y, X, Y and so on, starting with X. `mem_rdata` carries the addressed word in the cycle after the accepted read. The k-th pair on `op_x`/`op_y` is the word at the k-th X address and the word at the k-th Y address.
- R5: While `run` stays high, a tenure (`mem_req` continuously high) contains exactly `burst_limit` accepted reads. `mem_req` falls in the cycle after the last of these reads.
- R6: A `burst_limit` of 0 behaves as a limit of 1.
- R7: `mem_req` rises only at a clock edge at which `other_req` was sampled low and `run` was sampled high.
- R8: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_x` and `op_y` hold their values. Once the held pair's reads are done, no further reads are issued, but `mem_req` stays high.
- R9: With `run` low, `mem_req` and `op_valid` are 0 from the next cycle onward. When `run` rises again, both sequences restart at their base addresses.
- R10: `mem_rd` is high only while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables fetching; low restarts both windows |
| x_base | input | AW | X window base word address |
| x_len | input | AW | X window length in words |
| x_step | input | AW | X address step in words |
| y_base | input | AW | Y window base word address |
| y_len | input | AW | Y window length in words |
| y_step | input | AW | Y address step in words |
| burst_limit | input | BW | Accepted reads allowed per tenure (0 means 1) |
| other_req | input | 1 | Another master is waiting for the SRAM |
| mem_req | output | 1 | SRAM ownership request |
| mem_rd | output | 1 | Read strobe for the current word |
| mem_addr | output | AW | Word address of the read |
| mem_gnt | input | 1 | SRAM granted this cycle |
| mem_rdata | input | 32 | Read word, valid the cycle after an accepted read |
| op_valid | output | 1 | Operand pair available |
| op_ready | input | 1 | Consumer takes the pair |
| op_x | output | 32 | X operand |
| op_y | output | 32 | Y operand |

## Verification
Each result has its own latency. The read data is due one cycle after its accepted read, and the pair becomes valid two cycles after the Y read. `mem_req` falls one cycle after the last read of a tenure and rises one cycle after `other_req` was sampled low. The bench drives inputs just after the rising edge and samples everything at the falling edge. For those timing rules it compares tenure length, gaps and stall hold against the previous falling-edge sample at exact cycles. Addresses and operand values are checked by sequence order against bench-computed window positions, so random grant and ready gaps cannot shift the expected values.

// File: rtl/cof_pkg.sv
package cof_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic {TEN_IDLE = 1'b0, TEN_HOLD = 1'b1} tenure_e;
endpackage

// File: rtl/cof_circ_addr.sv
module cof_circ_addr #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] step,
   output logic [AW-1:0] addr
);
   localparam int SW = AW + 1;

   logic [AW-1:0] off;
   logic [SW-1:0] sum;
   logic [SW-1:0] nxt;

   assign sum  = {1'b0, off} + {1'b0, step};
   assign nxt  = (sum >= {1'b0, len}) ? (sum - {1'b0, len}) : sum;
   assign addr = base + off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   off <= '0;
      else if (clr) off <= '0;
      else if (adv) off <= nxt[AW-1:0];
   end

   // R2/R3: a legal window keeps the offset inside its length
   p_off_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && (step < len) && (off < len)) |=> (off < len));
endmodule

// File: rtl/cof_burst_ctrl.sv
module cof_burst_ctrl import cof_pkg::*; #(
   parameter int BW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          other_req,
   input  logic [BW-1:0] limit,
   input  logic          beat,
   output logic          own
);
   localparam int CW = BW + 1;

   tenure_e       st;
   logic [BW-1:0] cnt;
   logic [CW-1:0] lim_eff;
   logic [CW-1:0] cnt_nxt;

   assign lim_eff = (limit == '0) ? CW'(1) : {1'b0, limit};
   assign cnt_nxt = {1'b0, cnt} + CW'(1);
   assign own     = (st == TEN_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= TEN_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            TEN_IDLE: begin
               cnt <= '0;
               if (run && !other_req) st <= TEN_HOLD;
            end
            default: begin
               if (!run) begin
                  st <= TEN_IDLE;
               end else if (beat) begin
                  cnt <= cnt_nxt[BW-1:0];
                  if (cnt_nxt >= lim_eff) st <= TEN_IDLE;
               end
            end
         endcase
      end
   end

   // R5/R6: no read beyond the effective cap within one tenure
   p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own && beat && $stable(limit)) |-> ({1'b0, cnt} < lim_eff));

   // R7: ownership is only requested after a quiet cycle
   p_rise_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own) |-> $past(run && !other_req));
endmodule

// File: rtl/cof_operand_pair.sv
module cof_operand_pair import cof_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  cap_x,
   input  logic  cap_y,
   input  word_t rdata,
   input  logic  pop,
   output word_t x,
   output word_t y,
   output logic  valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x     <= '0;
         y     <= '0;
         valid <= 1'b0;
      end else begin
         if (cap_x && !clr) x <= rdata;
         if (cap_y && !clr) y <= rdata;
         if (clr)        valid <= 1'b0;
         else if (cap_y) valid <= 1'b1;
         else if (pop)   valid <= 1'b0;
      end
   end

   // R8: a stalled pair holds still
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop && !clr) |=> (valid && $stable(x) && $stable(y)));
endmodule

// File: rtl/circ_operand_fetch.sv
module circ_operand_fetch import cof_pkg::*; #(
   parameter int AW = 12,
   parameter int BW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [AW-1:0] x_base,
   input  logic [AW-1:0] x_len,
   input  logic [AW-1:0] x_step,
   input  logic [AW-1:0] y_base,
   input  logic [AW-1:0] y_len,
   input  logic [AW-1:0] y_step,
   input  logic [BW-1:0] burst_limit,
   input  logic          other_req,
   output logic          mem_req,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          op_valid,
   input  logic          op_ready,
   output logic [31:0]   op_x,
   output logic [31:0]   op_y
);
   localparam int NBUF = 2;

   if (AW < 2 || AW > 30) begin : g_bad_aw
      $error("circ_operand_fetch: AW must lie in 2..30");
   end
   if (BW < 1 || BW > 16) begin : g_bad_bw
      $error("circ_operand_fetch: BW must lie in 1..16");
   end

   logic [NBUF-1:0][AW-1:0] base_a;
   logic [NBUF-1:0][AW-1:0] len_a;
   logic [NBUF-1:0][AW-1:0] step_a;
   logic [NBUF-1:0][AW-1:0] addr_a;
   logic [NBUF-1:0]         adv_a;

   logic own;
   logic phase;      // 0: next read is X, 1: next read is Y
   logic x_inf;
   logic y_inf;
   logic slot_ok;
   logic want;
   logic beat;
   logic pop;

   assign base_a[0] = x_base;
   assign len_a[0]  = x_len;
   assign step_a[0] = x_step;
   assign base_a[1] = y_base;
   assign len_a[1]  = y_len;
   assign step_a[1] = y_step;

   assign pop      = op_valid && op_ready;
   assign slot_ok  = !op_valid || op_ready;
   assign want     = phase ? 1'b1 : (slot_ok && !y_inf);
   assign mem_req  = own;
   assign mem_rd   = own && run && want;
   assign beat     = mem_rd && mem_gnt;
   assign mem_addr = phase ? addr_a[1] : addr_a[0];
   assign adv_a[0] = beat && !phase;
   assign adv_a[1] = beat && phase;

   for (genvar g = 0; g < NBUF; g++) begin : g_win
      cof_circ_addr #(.AW(AW)) u_ag (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (!run),
         .adv  (adv_a[g]),
         .base (base_a[g]),
         .len  (len_a[g]),
         .step (step_a[g]),
         .addr (addr_a[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
         x_inf <= 1'b0;
         y_inf <= 1'b0;
      end else begin
         x_inf <= run && beat && !phase;
         y_inf <= run && beat && phase;
         if (!run)      phase <= 1'b0;
         else if (beat) phase <= !phase;
      end
   end

   cof_burst_ctrl #(.BW(BW)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .other_req(other_req),
      .limit    (burst_limit),
      .beat     (beat),
      .own      (own)
   );

   cof_operand_pair u_pair (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!run),
      .cap_x(x_inf),
      .cap_y(y_inf),
      .rdata(mem_rdata),
      .pop  (pop),
      .x    (op_x),
      .y    (op_y),
      .valid(op_valid)
   );

   // R4: a pair only becomes valid after its Y word has returned
   p_pair_after_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_valid) |-> $past(y_inf));
endmodule

// File: tb/circ_operand_fetch_bench.sv
module circ_operand_fetch_bench;
   localparam int AW = 12;
   localparam int BW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic [AW-1:0] xb = '0, xl = 12'd1, xs = '0, yb = '0, yl = 12'd1, ys = '0;
   logic [BW-1:0] lim = 6'd1;
   logic          other_req = 1'b0;
   logic          mem_gnt = 1'b0;
   logic          op_ready = 1'b0;
   logic [31:0]   mem_rdata = '0;
   logic          mem_req, mem_rd, op_valid;
   logic [AW-1:0] mem_addr;
   logic [31:0]   op_x, op_y;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   circ_operand_fetch #(.AW(AW), .BW(BW)) u_circ_operand_fetch (
      .clk(clk), .rst_n(rst_n), .run(run),
      .x_base(xb), .x_len(xl), .x_step(xs),
      .y_base(yb), .y_len(yl), .y_step(ys),
      .burst_limit(lim), .other_req(other_req),
      .mem_req(mem_req), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .op_valid(op_valid), .op_ready(op_ready), .op_x(op_x), .op_y(op_y)
   );

   function automatic logic [31:0] memf(input logic [AW-1:0] a);
      return ({20'd0, a} * 32'h9E37_79B1) ^ 32'hA5A5_0000;
   endfunction

   function automatic int next_off(input int off, input int len, input int step);
      int s = off + step;
      return (s >= len) ? s - len : s;
   endfunction

   function automatic int eff_lim(input logic [BW-1:0] l);
      return (l == 0) ? 1 : int'(l);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // memory model: word returns the cycle after an accepted read
   always @(posedge clk) if (mem_rd && mem_gnt) mem_rdata <= memf(mem_addr);

   // monitor, sampled at the falling edge
   int  b_xoff = 0, b_yoff = 0, b_phase = 0, p_xoff = 0, p_yoff = 0;
   int  ten_cnt = 0;
   bit  seen_low = 1'b1, first_beat = 1'b1;
   bit  prev_req = 1'b0, prev_other = 1'b0, prev_run = 1'b0, prev_stall = 1'b0;
   logic [31:0] prev_x = '0, prev_y = '0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_rd) chk(mem_req, "R10 rd without req", {31'd0, mem_req}, 32'd1);
         if (!prev_req && mem_req) begin
            chk(!prev_other && prev_run, "R7 rise after quiet", {31'd0, prev_other}, 32'd0);
            ten_cnt = 0;
            seen_low = 1'b0;
         end
         if (prev_req && !mem_req && !seen_low)
            chk(ten_cnt == eff_lim(lim), (lim == 0) ? "R6 tenure of one" : "R5 tenure length",
                ten_cnt, eff_lim(lim));
         if (!run) begin
            b_xoff = 0; b_yoff = 0; b_phase = 0; p_xoff = 0; p_yoff = 0;
            seen_low = 1'b1; first_beat = 1'b1;
         end else begin
            if (mem_rd && mem_gnt) begin
               logic [AW-1:0] ea;
               ea = (b_phase == 0) ? AW'(xb + AW'(b_xoff)) : AW'(yb + AW'(b_yoff));
               chk(mem_addr == ea, first_beat ? "R9 restart at base" :
                   ((b_phase == 0) ? "R2 x address" : "R3 y address"), mem_addr, ea);
               if (b_phase == 0) b_xoff = next_off(b_xoff, xl, xs);
               else              b_yoff = next_off(b_yoff, yl, ys);
               b_phase = 1 - b_phase;
               first_beat = 1'b0;
               ten_cnt++;
               chk(ten_cnt <= eff_lim(lim), "R5 cap", ten_cnt, eff_lim(lim));
            end
            if (prev_stall)
               chk(op_valid && op_x == prev_x && op_y == prev_y, "R8 stall hold", op_x, prev_x);
            if (op_valid && op_ready) begin
               logic [31:0] ex, ey;
               ex = memf(AW'(xb + AW'(p_xoff)));
               ey = memf(AW'(yb + AW'(p_yoff)));
               chk(op_x == ex, "R4 x operand", op_x, ex);
               chk(op_y == ey, "R4 y operand", op_y, ey);
               p_xoff = next_off(p_xoff, xl, xs);
               p_yoff = next_off(p_yoff, yl, ys);
            end
         end
         prev_stall = run && op_valid && !op_ready;
         prev_x = op_x; prev_y = op_y;
         prev_req = mem_req; prev_other = other_req; prev_run = run;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rand_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         mem_gnt   = ($urandom % 4) != 0;
         other_req = ($urandom % 4) == 0;
         op_ready  = ($urandom % 10) < 7;
      end
   endtask

   task automatic set_cfg(input int bx, input int lx, input int sx,
                          input int by, input int ly, input int sy, input int l);
      run = 1'b0; tick(2);
      xb = AW'(bx); xl = AW'(lx); xs = AW'(sx);
      yb = AW'(by); yl = AW'(ly); ys = AW'(sy);
      lim = BW'(l);
      tick(1);
   endtask

   initial begin
      void'($urandom(32'd7));
      tick(1);
      chk(!mem_req && !mem_rd && !op_valid, "R1 in reset", {mem_req, mem_rd, op_valid}, 0);
      rst_n = 1'b1;
      tick(2);
      chk(!mem_req && !mem_rd && !op_valid, "R1 after reset", {mem_req, mem_rd, op_valid}, 0);

      // directed: steady handshake, limit 3
      set_cfg(100, 5, 2, 300, 7, 3, 3);
      mem_gnt = 1; other_req = 0; op_ready = 1; run = 1;
      tick(200);

      // R9: run low clears outputs
      run = 0; tick(2);
      chk(!mem_req && !op_valid, "R9 run low", {mem_req, op_valid}, 0);
      run = 1; tick(60);

      // R6: limit 0 acts as 1
      set_cfg(4090, 9, 4, 17, 3, 1, 0);
      run = 1; tick(80);

      // R8: stall keeps ownership with no reads
      set_cfg(40, 6, 1, 80, 6, 5, 4);
      op_ready = 0; run = 1; tick(30);
      chk(mem_req && !mem_rd && op_valid, "R8 paused with req", {mem_req, mem_rd, op_valid}, 3'b101);
      op_ready = 1; tick(40);

      // R7: a waiting requester blocks re-acquisition
      other_req = 1;
      for (int i = 0; i < 40 && mem_req; i++) tick(1);
      tick(10);
      chk(!mem_req, "R7 held off", {31'd0, mem_req}, 0);
      other_req = 0; tick(2);
      chk(mem_req, "R7 resume", {31'd0, mem_req}, 1);

      // random configurations and handshake
      for (int k = 0; k < 5; k++) begin
         int lx = 1 + ($urandom % 20);
         int ly = 1 + ($urandom % 20);
         set_cfg($urandom % 4096, lx, $urandom % lx, $urandom % 4096, ly, $urandom % ly,
                 $urandom % 6);
         run = 1;
         rand_cycles(3000);
      end
      run = 0; tick(3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule